// File: doc/BRIEF.md
# Drive Self-Diagnostic Result Merger

This block sequences the diagnostic command on the master device of a two-device storage channel. A one-cycle start pulse, accepted while the block is idle, raises the busy flag. The master's own self-test is modelled as an input pair: a completion strobe and a result code. When the companion (slave) device is strapped present, the block also waits a bounded number of clock cycles for the slave's "passed diagnostics" signal.

When the master result is in and the slave question is settled, one of two codes goes into the error register. If the slave is absent or has passed, the register takes the master code unchanged. If the slave timed out, bit 7 is set on top of the master code. In the same cycle, busy drops and an interrupt pulse is raised. A status error bit flags any final code other than the all-good value.

The window length is a parameter counted in clock cycles. The default corresponds to five seconds at 250 MHz. A bench can shorten it.

Top module: `diag_combiner`

## Requirements
- R1: After reset, busy_o is 0, err_code_o is 01h, err_bit_o is 0 and irq_o is 0.
- R2: A start_i pulse sampled at a clock edge while busy_o is 0 sets busy_o right after that edge. A start_i pulse while busy_o is 1 has no effect: there is one completion and one interrupt.
- R3: While busy, the first cycle with local_done_i high captures local_code_i as the master code. The master codes are 01h pass, 02h formatter, 03h sector buffer, 04h ECC logic and 05h controller processor. A strobe given before the command is ignored.
- R4: With slave_present_i low, the final err_code_o equals the master code with bit 7 clear, whatever pdiag_ok_i does.
- R5: With slave_present_i high, pdiag_ok_i (active high, slave passed) sampled high at any of the first TIMEOUT_CYC edges after the start edge counts as a pass. The final code is then the master code. A pdiag_ok_i pulse before the start is ignored.
- R6: With slave_present_i high and no pdiag_ok_i in that window, the final code is the master code OR 80h. In that case busy_o stays high until edge TIMEOUT_CYC+1 after the start edge.
- R7: The command completes at the edge that follows the later of two events: the master code capture, and the slave pass or timeout. A slave that is absent counts as settled. At that edge busy_o falls and err_code_o takes the final code.
- R8: irq_o is high for exactly one cycle, in the first cycle with busy_o low after a command. err_code_o changes only in that cycle.
- R9: err_bit_o is 1 exactly when err_code_o differs from 01h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Diagnostic command start pulse |
| slave_present_i | input | 1 | Strap: companion device fitted |
| pdiag_ok_i | input | 1 | Companion passed its diagnostics (active high) |
| local_done_i | input | 1 | Master self-test finished strobe |
| local_code_i | input | CODE_W | Master self-test result code |
| busy_o | output | 1 | Command in progress |
| err_code_o | output | CODE_W | Error register value |
| err_bit_o | output | 1 | Status error flag |
| irq_o | output | 1 | One-cycle completion interrupt |

## Verification
The assertions check five things on every cycle:
- busy rises after an accepted start.
- The interrupt is a single pulse that coincides with busy falling.
- The error register moves only with the interrupt.
- The status error bit agrees with the code at completion.
- Bit 7 stays clear when no slave is fitted.

Only the bench scenarios can show three further behaviours. The first is the exact completion cycle for each ordering of master and slave events. The second is the pass/fail boundary at the last window edge and the one after it. The third is that stray strobes before a command, and restarts during one, are ignored.

// File: rtl/diag_pkg.sv
package diag_pkg;
  typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_RUN = 1'b1} diag_state_e;
  localparam int unsigned CODE_W_DEF = 8;
  localparam logic [CODE_W_DEF-1:0] CODE_PASS = 8'h01;
  localparam logic [CODE_W_DEF-1:0] SLAVE_FAIL_MASK = 8'h80;
endpackage

// File: rtl/diag_slave_watch.sv
module diag_slave_watch #(
  parameter int unsigned TIMEOUT_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  input  logic pdiag_ok_i,
  output logic resolved_o,
  output logic failed_o
);
  localparam int unsigned CNT_W = (TIMEOUT_CYC < 2) ? 1 : $clog2(TIMEOUT_CYC);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic pass_q, tout_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pass_q <= 1'b0;
      tout_q <= 1'b0;
    end else if (clear_i) begin
      cnt_q  <= '0;
      pass_q <= 1'b0;
      tout_q <= 1'b0;
    end else if (run_i && !pass_q && !tout_q) begin
      // pass wins over timeout on the last window edge
      if (pdiag_ok_i)         pass_q <= 1'b1;
      else if (cnt_q == LAST) tout_q <= 1'b1;
      else                    cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign resolved_o = pass_q | tout_q;
  assign failed_o   = tout_q;
endmodule

// File: rtl/diag_local_latch.sv
module diag_local_latch #(
  parameter int unsigned CODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              run_i,
  input  logic              done_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              done_o,
  output logic [CODE_W-1:0] code_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0;
      code_o <= '0;
    end else if (clear_i) begin
      done_o <= 1'b0;
      code_o <= '0;
    end else if (run_i && done_i && !done_o) begin
      done_o <= 1'b1;
      code_o <= code_i;
    end
  end
endmodule

// File: rtl/diag_seq.sv
module diag_seq
  import diag_pkg::*;
#(
  parameter int unsigned CODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              slave_present_i,
  input  logic              local_done_i,
  input  logic [CODE_W-1:0] local_code_i,
  input  logic              slave_resolved_i,
  input  logic              slave_failed_i,
  output logic              accept_o,
  output logic              run_o,
  output logic              busy_o,
  output logic [CODE_W-1:0] err_code_o,
  output logic              err_bit_o,
  output logic              irq_o
);
  localparam logic [CODE_W-1:0] PASS_C = CODE_W'(CODE_PASS);
  localparam logic [CODE_W-1:0] FAIL_M = CODE_W'(SLAVE_FAIL_MASK);

  diag_state_e state_q;
  logic finish;
  logic [CODE_W-1:0] final_code;

  assign run_o    = (state_q == ST_RUN);
  assign accept_o = (state_q == ST_IDLE) && start_i;
  assign finish   = run_o && local_done_i && (!slave_present_i || slave_resolved_i);
  assign final_code = local_code_i | ((slave_present_i && slave_failed_i) ? FAIL_M : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      err_code_o <= PASS_C;
      err_bit_o  <= 1'b0;
      irq_o      <= 1'b0;
    end else begin
      irq_o <= 1'b0;
      if (accept_o) begin
        state_q <= ST_RUN;
      end else if (finish) begin
        state_q    <= ST_IDLE;
        err_code_o <= final_code;
        err_bit_o  <= (final_code != PASS_C);
        irq_o      <= 1'b1;
      end
    end
  end

  assign busy_o = run_o;
endmodule

// File: rtl/diag_combiner.sv
module diag_combiner #(
  parameter int unsigned CODE_W      = 8,
  parameter int unsigned TIMEOUT_CYC = 1250000000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              slave_present_i,
  input  logic              pdiag_ok_i,
  input  logic              local_done_i,
  input  logic [CODE_W-1:0] local_code_i,
  output logic              busy_o,
  output logic [CODE_W-1:0] err_code_o,
  output logic              err_bit_o,
  output logic              irq_o
);
  logic accept, run, l_done, s_res, s_fail;
  logic [CODE_W-1:0] l_code;

  diag_local_latch #(.CODE_W(CODE_W)) i_local (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(accept), .run_i(run),
    .done_i(local_done_i), .code_i(local_code_i),
    .done_o(l_done), .code_o(l_code)
  );

  diag_slave_watch #(.TIMEOUT_CYC(TIMEOUT_CYC)) i_watch (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(accept), .run_i(run),
    .pdiag_ok_i(pdiag_ok_i), .resolved_o(s_res), .failed_o(s_fail)
  );

  diag_seq #(.CODE_W(CODE_W)) i_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .slave_present_i(slave_present_i),
    .local_done_i(l_done), .local_code_i(l_code),
    .slave_resolved_i(s_res), .slave_failed_i(s_fail),
    .accept_o(accept), .run_o(run), .busy_o(busy_o),
    .err_code_o(err_code_o), .err_bit_o(err_bit_o), .irq_o(irq_o)
  );
endmodule

// File: rtl/diag_combiner_chk.sv
module diag_combiner_chk #(
  parameter int unsigned CODE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              slave_present_i,
  input logic              busy_o,
  input logic [CODE_W-1:0] err_code_o,
  input logic              err_bit_o,
  input logic              irq_o
);
  p_busy_on_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> busy_o);

  p_irq_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  p_irq_with_fall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> irq_o);

  p_irq_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !busy_o);

  p_code_moves_with_irq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(err_code_o) |-> irq_o);

  p_err_bit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (err_bit_o == (err_code_o != CODE_W'(8'h01))));

  p_no_slave_bit7_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !slave_present_i) |-> !err_code_o[CODE_W-1]);
endmodule

bind diag_combiner diag_combiner_chk #(.CODE_W(CODE_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
  .slave_present_i(slave_present_i), .busy_o(busy_o),
  .err_code_o(err_code_o), .err_bit_o(err_bit_o), .irq_o(irq_o)
);

// File: tb/test_diag_combiner.sv
`timescale 1ns/1ps
module test_diag_combiner;
  localparam int T = 16;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic start_i = 0, slave_present_i = 0, pdiag_ok_i = 0, local_done_i = 0;
  logic [7:0] local_code_i = '0;
  logic busy_o, err_bit_o, irq_o;
  logic [7:0] err_code_o;

  int checks = 0, fails = 0, cyc = 0;
  logic [8:0] exp_q[$];
  logic irq_prev = 1'b0;

  always #2 clk_i = ~clk_i;

  diag_combiner #(.CODE_W(8), .TIMEOUT_CYC(T)) i_diag_combiner (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pop expected result on each interrupt
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (irq_o) begin
        logic [8:0] e;
        if (exp_q.size() == 0) begin
          chk("R2 spurious irq", 1, 0);
        end else begin
          e = exp_q.pop_front();
          chk("R3 err_code", int'(err_code_o), int'(e[7:0]));
          chk("R9 err_bit", int'(err_bit_o), int'(e[8]));
        end
        chk("R8 irq width", int'(irq_prev), 0);
      end
      irq_prev <= irq_o;
    end
  end

  task automatic run_cmd(input bit slave, input logic [7:0] code, input int d,
                         input int p, input bit pre, input bit restart);
    bit pass;
    int res, f;
    logic [7:0] e;
    string tag;
    pass = slave && p >= 1 && p <= T;
    res  = !slave ? 0 : (pass ? p : T);
    f    = ((d > res) ? d : res) + 1;
    e    = code | ((slave && !pass) ? 8'h80 : 8'h00);
    exp_q.push_back({e != 8'h01, e});
    if (pre) begin // stray strobes while idle
      @(negedge clk_i);
      pdiag_ok_i = 1; local_done_i = 1; local_code_i = 8'h05;
      @(negedge clk_i);
      pdiag_ok_i = 0; local_done_i = 0;
    end
    @(negedge clk_i);
    slave_present_i = slave; start_i = 1; local_code_i = code;
    @(negedge clk_i);
    start_i = 0;
    for (int j = 0; j <= f + 1; j++) begin
      tag = (j == 0) ? "R2 busy" : ((slave && !pass) ? "R6 busy" : "R7 busy");
      chk(tag, int'(busy_o), int'(j < f));
      pdiag_ok_i   = (j + 1 == p);
      local_done_i = (j + 1 == d);
      start_i      = restart && (j == 1);
      @(negedge clk_i);
    end
    pdiag_ok_i = 0; local_done_i = 0; start_i = 0;
  endtask

  initial begin
    #9;
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 err_code", int'(err_code_o), 'h01);
    chk("R1 err_bit", int'(err_bit_o), 0);
    chk("R1 irq", int'(irq_o), 0);
    rst_ni = 1'b1;
    run_cmd(0, 8'h01, 3, 0, 0, 0);   // R4 no slave, pass
    run_cmd(0, 8'h03, 2, 2, 0, 0);   // R4 pdiag ignored, R9
    run_cmd(1, 8'h01, 3, 6, 0, 0);   // R5 slave passes
    run_cmd(1, 8'h04, 9, 2, 0, 0);   // R7 local later
    run_cmd(1, 8'h02, 2, 0, 0, 0);   // R6 timeout
    run_cmd(1, 8'h01, 1, T, 0, 0);   // R5 last window edge
    run_cmd(1, 8'h01, 1, T + 1, 0, 0); // R6 one edge late
    run_cmd(1, 8'h05, 4, 3, 1, 0);   // R3 stray done ignored
    run_cmd(1, 8'h01, 2, 0, 1, 0);   // R5 stray pdiag ignored
    run_cmd(0, 8'h01, 5, 0, 0, 1);   // R2 restart ignored
    repeat (4) @(negedge clk_i);
    chk("R8 irq count", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected <20000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule